// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a word-select line and a data line. It turns the link into parallel 18-bit left and right samples. Both samples are updated together, with a one-cycle strobe, once per stereo frame. The whole block runs on the bit clock and samples its serial inputs on the rising edge. All of its outputs are registered, so a downstream sample-rate stage can take them directly.

A static 2-bit format input chooses the framing. Two right-justified framings place the word at the end of each half-frame, as 16 or 18 bits. One left-justified framing places an 18-bit word at the start of each half-frame. An I2S-style framing delays the MSB by one bit clock. Words are always sent MSB first in two's complement. A 16-bit word is presented in the 18-bit output with two zero LSBs. In the left-justified and I2S framings, a 16-bit word followed by two zero bits gives the same result.

An active-high run input acts as a power-down control. While it is low, the block is held in synchronous reset and its outputs read zero. Once it is released, nothing is captured until the first rising edge of word select.

Top module: `aud_serial_rx`

## Requirements
- R1: `fmt_sel` is sampled on every rising edge of `clk` and selects the framing: 00 = 16-bit right-justified, 01 = 18-bit right-justified, 10 = 18-bit left-justified, 11 = I2S-style. `sdat` and `ws` are sampled on the rising `clk` edge, and data is MSB first in two's complement.
- R2: In format 00, `ws` high marks the left half. The word is the last 16 bits sampled before the `ws` transition, and earlier bits are ignored. The output is the word in bits 17:2 with bits 1:0 equal to zero, so the two low bits of every sample are zero.
- R3: In format 01, `ws` high marks the left half. The word is the last 18 bits sampled before the `ws` transition, and all earlier bits in the half are ignored.
- R4: In format 10, `ws` high marks the left half. The MSB is the first bit sampled after the `ws` transition, and 18 bits are taken. Bits after the 18th are ignored. A 16-bit word followed by two zero bits is output as that word in bits 17:2.
- R5: In format 11, `ws` low marks the left half. The MSB is sampled one bit clock after the `ws` transition. With 16 bit clocks per half, the LSB of a 16-bit word falls in the first bit clock of the next half, and bits 1:0 read zero. With 18 or more bit clocks per half, 18 bits are taken.
- R6: `frame_vld` is high for exactly one cycle per frame, and `left_smp` and `right_smp` change only in that cycle. In formats 00 to 10, it rises at the clock edge that samples the first bit of the following left half. In format 11, it rises one bit clock later.
- R7: While `pwr_on` is low, the block is reset synchronously. After the next clock edge, `left_smp` and `right_smp` are zero and `frame_vld` is low.
- R8: After `pwr_on` goes high, no word is captured until the first rising edge of `ws`. A frame is delivered only when a left word was completed before its right word since that edge. In format 11, the first delivered frame is therefore the first full left/right pair after that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all inputs sampled on its rising edge |
| pwr_on | input | 1 | Run control; low holds the block in synchronous reset |
| fmt_sel | input | 2 | Framing select (see R1) |
| ws | input | 1 | Word-select (channel) clock |
| sdat | input | 1 | Serial audio data |
| left_smp | output | 18 | Left sample, two's complement, left-aligned |
| right_smp | output | 18 | Right sample, two's complement, left-aligned |
| frame_vld | output | 1 | One-cycle strobe when both samples update |

## Verification
Two conditions are hardest to reach from the ports. The first is the start-up gate: a run of junk with both word-select levels arrives before the first rising edge, and a receiver without the gate would deliver it as a frame. The second is the I2S-style case with 16 bit clocks per half, where each word's LSB falls in the next half-frame. Every segment therefore starts from power-down and sends junk halves at both word-select levels before real frames. The I2S-style segments cover 16, 18, 20 and 32 bit clocks per half, so the wrapped LSB, the exact-fit 18-bit word and the padded 16-bit word are all exercised.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ18 = 2'b01,
    FMT_LJ18 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;
endpackage

// File: rtl/ws_tracker.sv
module ws_tracker (
  input  logic clk,
  input  logic rst,
  input  logic ws,
  output logic ws_prev,
  output logic edge_now,
  output logic live,
  output logic armed
);
  logic rise;

  always_comb begin
    edge_now = ws ^ ws_prev;
    rise     = ws & ~ws_prev;
    live     = armed | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev <= 1'b1;
      armed   <= 1'b0;
    end else begin
      ws_prev <= ws;
      if (rise) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/word_capture.sv
module word_capture
  import aud_rx_pkg::*;
#(
  parameter int W  = 18,
  parameter int SW = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   fmt,
  input  logic         ws,
  input  logic         ws_prev,
  input  logic         sdat,
  input  logic         edge_now,
  input  logic         live,
  input  logic         armed,
  output logic         done,
  output logic         done_left,
  output logic [W-1:0] done_word
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr;
  logic [W-1:0]  acc;
  logic [CW-1:0] nbits;
  logic          have_word;
  logic          acc_left;
  logic          edge_d;
  logic          is_rj;
  logic          is_i2s;
  logic          start;

  always_comb begin
    is_rj  = (fmt == FMT_RJ16) || (fmt == FMT_RJ18);
    is_i2s = (fmt == FMT_I2S);
    start  = is_i2s ? edge_d : (live & edge_now);
    if (is_rj) begin
      done      = armed & edge_now;
      done_left = ws_prev;
      done_word = (fmt == FMT_RJ16) ? {sr[SW-1:0], {(W-SW){1'b0}}} : sr;
    end else begin
      done      = start & have_word;
      done_left = acc_left;
      done_word = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      acc       <= '0;
      nbits     <= '0;
      have_word <= 1'b0;
      acc_left  <= 1'b0;
      edge_d    <= 1'b0;
    end else begin
      sr     <= {sr[W-2:0], sdat};
      edge_d <= live & edge_now;
      if (start) begin
        acc       <= {sdat, {(W-1){1'b0}}};
        nbits     <= CW'(1);
        have_word <= 1'b1;
        acc_left  <= ws ^ is_i2s;
      end else if (int'(nbits) < W) begin
        for (int k = 1; k < W; k++) begin
          if (int'(nbits) == k) acc[W-1-k] <= sdat;
        end
        nbits <= nbits + CW'(1);
      end
    end
  end
endmodule

// File: rtl/frame_assembler.sv
module frame_assembler #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done,
  input  logic         done_left,
  input  logic [W-1:0] done_word,
  output logic [W-1:0] left_smp,
  output logic [W-1:0] right_smp,
  output logic         frame_vld
);
  logic [W-1:0] lhold;
  logic         got_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      lhold     <= '0;
      got_left  <= 1'b0;
      left_smp  <= '0;
      right_smp <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (done && done_left) begin
        lhold    <= done_word;
        got_left <= 1'b1;
      end else if (done && got_left) begin
        left_smp  <= lhold;
        right_smp <= done_word;
        frame_vld <= 1'b1;
        got_left  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W = 18,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                pwr_on,
  input  logic [1:0]          fmt_sel,
  input  logic                ws,
  input  logic                sdat,
  output logic [SAMPLE_W-1:0] left_smp,
  output logic [SAMPLE_W-1:0] right_smp,
  output logic                frame_vld
);
  logic                rst;
  logic                ws_prev;
  logic                edge_now;
  logic                live;
  logic                armed;
  logic                done;
  logic                done_left;
  logic [SAMPLE_W-1:0] done_word;

  assign rst = ~pwr_on;

  ws_tracker i_ws (
    .clk      (clk),
    .rst      (rst),
    .ws       (ws),
    .ws_prev  (ws_prev),
    .edge_now (edge_now),
    .live     (live),
    .armed    (armed)
  );

  word_capture #(.W(SAMPLE_W), .SW(SHORT_W)) i_cap (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt_sel),
    .ws        (ws),
    .ws_prev   (ws_prev),
    .sdat      (sdat),
    .edge_now  (edge_now),
    .live      (live),
    .armed     (armed),
    .done      (done),
    .done_left (done_left),
    .done_word (done_word)
  );

  frame_assembler #(.W(SAMPLE_W)) i_asm (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .done_left (done_left),
    .done_word (done_word),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .frame_vld (frame_vld)
  );
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         pwr_on,
  input logic [1:0]   fmt_sel,
  input logic         ws,
  input logic [W-1:0] left_smp,
  input logic [W-1:0] right_smp,
  input logic         frame_vld
);
  logic ws_p;
  logic seen_rise;
  logic seen_q;
  logic pd_q = 1'b0;

  always_ff @(posedge clk) begin
    pd_q <= ~pwr_on;
    if (!pwr_on) begin
      ws_p      <= 1'b1;
      seen_rise <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      ws_p   <= ws;
      seen_q <= seen_rise;
      if (ws && !ws_p) seen_rise <= 1'b1;
    end
  end

  // R7: outputs cleared after a clock edge with power-down asserted
  always @(posedge clk) begin
    if (pd_q) begin
      a_r7_pd_zero: assert (left_smp == '0 && right_smp == '0 && !frame_vld)
        else $error("R7 outputs not cleared in power-down");
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!pwr_on)
    frame_vld |=> !frame_vld);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!pwr_on)
    ($past(pwr_on) && !frame_vld) |-> ($stable(left_smp) && $stable(right_smp)));

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!pwr_on)
    (frame_vld && fmt_sel == 2'b00) |-> (left_smp[1:0] == 2'b00 && right_smp[1:0] == 2'b00));

  a_r8_no_early_frame: assert property (@(posedge clk) disable iff (!pwr_on)
    frame_vld |-> seen_q);
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.W(SAMPLE_W)) i_chk (.*);

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;
  localparam int W = 18;

  typedef struct {
    bit          pwr;
    bit [1:0]    fmt;
    bit          ws;
    bit          sd;
    bit          ev;
    logic [W-1:0] l;
    logic [W-1:0] r;
    string       tag;
  } ent_t;

  logic         clk = 1'b0;
  logic         pwr_on = 1'b0;
  logic [1:0]   fmt_sel = 2'b00;
  logic         ws = 1'b1;
  logic         sdat = 1'b0;
  logic [W-1:0] left_smp;
  logic [W-1:0] right_smp;
  logic         frame_vld;

  ent_t         q[$];
  bit           pend = 0;
  logic [W-1:0] pl, pr;
  bit           spill = 0;
  bit [1:0]     cur_fmt = 0;
  int           errors = 0;
  int           checks = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  aud_serial_rx i_aud_serial_rx (
    .clk(clk), .pwr_on(pwr_on), .fmt_sel(fmt_sel), .ws(ws), .sdat(sdat),
    .left_smp(left_smp), .right_smp(right_smp), .frame_vld(frame_vld)
  );

  function automatic string fmt_tag(bit [1:0] f);
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic push(bit p, bit w, bit d, bit ev, logic [W-1:0] l, logic [W-1:0] r, string tag);
    ent_t e;
    e.pwr = p; e.fmt = cur_fmt; e.ws = w; e.sd = d; e.ev = ev; e.l = l; e.r = r; e.tag = tag;
    q.push_back(e);
  endtask

  // R7: power-down cycles
  task automatic powerdown(int n);
    for (int i = 0; i < n; i++) push(0, 1, 1'($urandom), 0, '0, '0, "R7");
    pend = 0;
  endtask

  // R8: junk before the first rising word-select edge
  task automatic junk(int n, bit w);
    for (int i = 0; i < n; i++) push(1, w, 1'($urandom), 0, '0, '0, "R8");
  endtask

  // One half-frame; e is the expected 18-bit output for this word
  task automatic half(bit isleft, logic [W-1:0] e, int h);
    bit wsv;
    wsv = (cur_fmt == 2'd3) ? !isleft : isleft;
    for (int i = 0; i < h; i++) begin
      bit d;
      bit ev;
      string tg;
      d  = 1'($urandom);
      ev = 0;
      tg = fmt_tag(cur_fmt);
      case (cur_fmt)
        2'd0: if (i >= h - 16) d = e[17 - (i - (h - 16))];
        2'd1: if (i >= h - 18) d = e[17 - (i - (h - 18))];
        2'd2: if (i < 18) d = e[17 - i];
        default: begin
          if (i == 0) d = spill;
          else if (i - 1 < 18) d = e[17 - (i - 1)];
        end
      endcase
      if (isleft && pend && ((cur_fmt != 2'd3 && i == 0) || (cur_fmt == 2'd3 && i == 1))) begin
        ev = 1;
        pend = 0;
        tg = {tg, " R6"};
      end
      push(1, wsv, d, ev, pl, pr, tg);
    end
    if (cur_fmt == 2'd3) spill = (h <= 18) ? e[17 - (h - 1)] : 1'($urandom);
  endtask

  task automatic frame(logic [W-1:0] el, logic [W-1:0] er, int h, bit counts);
    half(1, el, h);
    half(0, er, h);
    if (counts) begin
      pend = 1; pl = el; pr = er;
    end
  endtask

  function automatic logic [W-1:0] mkword(bit short16, int k);
    logic [W-1:0] v;
    v = W'($urandom);
    if (k == 1) v = 18'h1FFFF;
    if (k == 2) v = 18'h20000;
    if (short16) v[1:0] = 2'b00;
    return v;
  endfunction

  // R1: one segment per format / bit clocks per half
  task automatic segment(bit [1:0] f, int h, int nfr, bit short16);
    powerdown(3);
    cur_fmt = f;
    powerdown(2);
    junk(7, 1);
    junk(9, 0);
    for (int k = 0; k < nfr + 1; k++) begin
      bit cnt;
      cnt = !(f == 2'd3 && k == 0);
      frame(mkword(short16 || f == 2'd0, k), mkword(short16 || f == 2'd0, k + 1), h, cnt);
    end
    frame(mkword(0, 0), mkword(0, 0), h, 0);  // completes the last counted frame
  endtask

  task automatic check_entry(ent_t e, ref logic [W-1:0] hl, ref logic [W-1:0] hr);
    bit ev;
    ev = 0;
    if (!e.pwr) begin
      hl = '0; hr = '0;
    end else if (e.ev) begin
      hl = e.l; hr = e.r; ev = 1;
    end
    checks++;
    if (frame_vld !== ev || left_smp !== hl || right_smp !== hr) begin
      errors++;
      $display("FAIL %s: vld=%0b exp %0b left=%h exp %h right=%h exp %h",
               e.tag, frame_vld, ev, left_smp, hl, right_smp, hr);
    end
  endtask

  initial begin
    // R2 R3: right-justified framings
    segment(2'd0, 16, 3, 1);
    segment(2'd0, 24, 2, 1);
    segment(2'd1, 18, 3, 0);
    segment(2'd1, 32, 2, 0);
    // R4: left-justified, 18-bit and 16-bit with two zeros
    segment(2'd2, 18, 2, 0);
    segment(2'd2, 20, 2, 1);
    segment(2'd2, 32, 2, 1);
    // R5: I2S-style with wrapped LSB, exact fit and padded words
    segment(2'd3, 16, 3, 1);
    segment(2'd3, 18, 2, 0);
    segment(2'd3, 32, 2, 1);
    segment(2'd3, 20, 2, 0);
    powerdown(3);
  end

  initial begin : runner
    logic [W-1:0] hl;
    logic [W-1:0] hr;
    ent_t prev;
    ent_t cur;
    bit have_prev;
    hl = '0; hr = '0; have_prev = 0;
    #1;
    forever begin
      @(negedge clk);
      if (have_prev) check_entry(prev, hl, hr);
      if (q.size() == 0) break;
      cur = q.pop_front();
      pwr_on  = cur.pwr;
      fmt_sel = cur.fmt;
      ws      = cur.ws;
      sdat    = cur.sd;
      prev = cur;
      have_prev = 1;
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule